// File: doc/BRIEF.md
# Late-Write Pipelined Burst SRAM

A synthesizable single-clock model of a pipelined burst static memory. Write data follows its command by the same two-cycle distance that separates a read command from its returned data, so reads and writes can be issued back to back in any mix with no idle bus cycles between them. A command is loaded when the advance input is low. It then carries an address, three chip selects and a read/write direction. On cycles where advance is high, the model steps an internal 2-bit burst counter through the low address bits instead. It can step in interleaved (XOR) or linear (modulo add) order.

A clock-hold input freezes every pipeline stage and the burst state. A synchronous reset returns the model to a deselected, idle state. The data path is split into a write bus and a read bus. The read bus carries a drive indication, gated by an asynchronous output enable, and a read-valid flag that is aligned with the read latency. The storage is a small register array with 8-bit lanes that can be written independently.

Top module: `lw_burst_sram`

## Requirements
- R1: With `adv` low and the chip selected, a load cycle captures `addr` and the direction: `rd_wr_n` = 1 starts a read and `rd_wr_n` = 0 starts a write.
- R2: Read data for a command sampled at enabled edge k is presented on `rdata` with `rdata_valid` = 1 after enabled edge k+2, and is held until the next enabled edge.
- R3: For a write sampled at enabled edge k, `wdata` and `lane_we_n` are taken at enabled edge k+2. A read of the same address issued on the very next cycle returns the new data.
- R4: With `adv` high, `addr`, the chip selects and `rd_wr_n` are ignored. The burst keeps the direction of its load cycle and keeps the upper address bits.
- R5: With `burst_lin` = 0, beat n (n = 0..3) uses low address bits start XOR n. With `burst_lin` = 1 it uses (start + n) mod 4. The fifth beat returns to the start address.
- R6: A load cycle with `sel_a_n` = 1, `sel_b` = 0 or `sel_c_n` = 1 performs no operation. Later continue cycles also stay idle, so `rdata_valid` is 0 two enabled cycles afterwards.
- R7: While `hold` = 1, no pipeline or burst state changes and no array write occurs. `rdata_valid` and `rdata` keep their values.
- R8: `lane_we_n[i]` (active low) gates byte lane i, which is `wdata[8i+7:8i]`. A write with all lane enables high changes nothing.
- R9: `rdata_drive` = 1 only when `rdata_valid` = 1 and `out_en_n` = 0, and `rdata` is 0 whenever `rdata_drive` = 0. Write commands never set `rdata_valid`.
- R10: A synchronous `rst` clears the pipeline and burst state. Afterwards `rdata_valid` and `rdata_drive` are 0, and continue cycles perform nothing until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Clock hold: 1 freezes all state |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new command, 1 = continue burst |
| rd_wr_n | input | 1 | Direction on load: 1 read, 0 write |
| lane_we_n | input | LANES | Per-lane write enables, active low, taken with write data |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*8 | Write data bus |
| burst_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*8 | Read data, 0 when not driven |
| rdata_drive | output | 1 | Read bus is being driven |
| rdata_valid | output | 1 | Read data valid, two enabled cycles after a read command |

## Verification
Every result is due a fixed number of enabled edges after its stimulus. Read data and `rdata_valid` follow a command after the second enabled edge. Write data goes onto the bus two cycles after its command. A hold cycle pushes both out by one cycle. The bench drives inputs on the falling edge and checks outputs on the next falling edge. Its vector table therefore lists, for each row, the result of the command two rows earlier, and the directed burst, hold and reset sequences index their expectations in the same way.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // Low two address bits of a burst beat: XOR order or modulo-4 add order.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       lin);
        logic [1:0] sum;
        sum = start + cnt;
        return lin ? sum : (start ^ cnt);
    endfunction

endpackage

// File: rtl/lwsram_burst_ctl.sv
module lwsram_burst_ctl
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              adv,
    input  logic              rd_wr_n,
    input  logic              sel_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_lin,
    output logic              iss_vld,
    output op_e               iss_op,
    output logic [ADDR_W-1:0] iss_addr
);

    typedef struct packed {
        logic              active;
        op_e               op;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        iss_vld  = 1'b0;
        iss_op   = st_q.op;
        iss_addr = st_q.base;
        if (!adv) begin
            iss_vld     = sel_ok;
            iss_op      = rd_wr_n ? OP_RD : OP_WR;
            iss_addr    = addr;
            st_d.active = sel_ok;
            st_d.op     = iss_op;
            st_d.base   = addr;
            st_d.cnt    = 2'd1;
        end else begin
            iss_vld  = st_q.active;
            iss_op   = st_q.op;
            iss_addr = {st_q.base[ADDR_W-1:2],
                        beat_low(st_q.base[1:0], st_q.cnt, burst_lin)};
            st_d.cnt = st_q.cnt + 2'd1;
        end
        if (hold) begin
            st_d = st_q;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_en[i]) begin
                    mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    adv,
    input  logic                    rd_wr_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    burst_lin,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive,
    output logic                    rdata_valid
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              s1_vld;
        op_e               s1_op;
        logic [ADDR_W-1:0] s1_addr;
        logic              s2_vld;
        op_e               s2_op;
        logic [ADDR_W-1:0] s2_addr;
        logic              out_vld;
        logic [DATA_W-1:0] out_data;
    } pipe_t;

    pipe_t pp_d, pp_q;

    logic              sel_ok;
    logic              iss_vld;
    op_e               iss_op;
    logic [ADDR_W-1:0] iss_addr;
    logic              arr_we;
    logic [DATA_W-1:0] arr_rdata;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    lwsram_burst_ctl #(.ADDR_W(ADDR_W)) burst_i (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .adv      (adv),
        .rd_wr_n  (rd_wr_n),
        .sel_ok   (sel_ok),
        .addr     (addr),
        .burst_lin(burst_lin),
        .iss_vld  (iss_vld),
        .iss_op   (iss_op),
        .iss_addr (iss_addr)
    );

    // Stage two commits writes with the bus data of this edge.
    assign arr_we = !hold && pp_q.s2_vld && (pp_q.s2_op == OP_WR);

    lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk    (clk),
        .we     (arr_we),
        .lane_en(~lane_we_n),
        .waddr  (pp_q.s2_addr),
        .wdata  (wdata),
        .raddr  (pp_q.s2_addr),
        .rdata  (arr_rdata)
    );

    always_comb begin
        pp_d = pp_q;
        if (!hold) begin
            pp_d.s1_vld   = iss_vld;
            pp_d.s1_op    = iss_op;
            pp_d.s1_addr  = iss_addr;
            pp_d.s2_vld   = pp_q.s1_vld;
            pp_d.s2_op    = pp_q.s1_op;
            pp_d.s2_addr  = pp_q.s1_addr;
            pp_d.out_vld  = pp_q.s2_vld && (pp_q.s2_op == OP_RD);
            pp_d.out_data = pp_d.out_vld ? arr_rdata : '0;
        end
        if (rst) begin
            pp_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        pp_q <= pp_d;
    end

    assign rdata_valid = pp_q.out_vld;
    assign rdata_drive = pp_q.out_vld && !out_en_n;
    assign rdata       = rdata_drive ? pp_q.out_data : '0;

endmodule

// File: rtl/lw_burst_sram_chk.sv
module lw_burst_sram_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    hold,
    input logic                    sel_a_n,
    input logic                    sel_b,
    input logic                    sel_c_n,
    input logic                    adv,
    input logic                    rd_wr_n,
    input logic                    out_en_n,
    input logic [LANES*LANE_W-1:0] rdata,
    input logic                    rdata_drive,
    input logic                    rdata_valid
);

    logic sel_all;
    assign sel_all = !sel_a_n && sel_b && !sel_c_n;

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && sel_all && rd_wr_n) ##1 !hold ##1 !hold |=> rdata_valid);

    // R9
    write_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && sel_all && !rd_wr_n) ##1 !hold ##1 !hold |=> !rdata_valid);

    // R6
    deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && !sel_all) ##1 (!hold && adv) ##1 !hold |=> !rdata_valid);

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(rdata_valid));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!rdata_valid && !rdata_drive));

    // R9
    drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rdata_drive |-> (!out_en_n && rdata_valid));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rdata_valid |-> (rdata == '0));

endmodule

bind lw_burst_sram lw_burst_sram_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .adv        (adv),
    .rd_wr_n    (rd_wr_n),
    .out_en_n   (out_en_n),
    .rdata      (rdata),
    .rdata_drive(rdata_drive),
    .rdata_valid(rdata_valid)
);

// File: tb/lw_burst_sram_tb_top.sv
module lw_burst_sram_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst, hold, sel_a_n, sel_b, sel_c_n, adv, rd_wr_n;
    logic [3:0]  lane_we_n;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        burst_lin, out_en_n;
    logic [31:0] rdata;
    logic        rdata_drive, rdata_valid;

    int ntot = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lw_burst_sram dut_i (
        .clk(clk), .rst(rst), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .adv(adv), .rd_wr_n(rd_wr_n), .lane_we_n(lane_we_n),
        .addr(addr), .wdata(wdata), .burst_lin(burst_lin), .out_en_n(out_en_n),
        .rdata(rdata), .rdata_drive(rdata_drive), .rdata_valid(rdata_valid)
    );

    // ld: 1 = load (adv low); sel: 1 = all selects active; ev/ed: result after this edge
    typedef struct packed {
        logic        ld;
        logic        rd;
        logic        sel;
        logic [5:0]  a;
        logic [31:0] wd;
        logic [3:0]  be_n;
        logic        ev;
        logic [31:0] ed;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b1, 1'b0, 1'b1, 6'h10, 32'h0,        4'hF, 1'b0, 32'h0},
        '{1'b1, 1'b0, 1'b1, 6'h11, 32'h0,        4'hF, 1'b0, 32'h0},
        '{1'b1, 1'b1, 1'b1, 6'h10, 32'hA1A2A3A4, 4'h0, 1'b0, 32'h0},
        '{1'b1, 1'b1, 1'b1, 6'h11, 32'hB1B2B3B4, 4'h0, 1'b0, 32'h0},
        '{1'b1, 1'b0, 1'b1, 6'h10, 32'h0,        4'hF, 1'b1, 32'hA1A2A3A4},
        '{1'b1, 1'b1, 1'b1, 6'h10, 32'h0,        4'hF, 1'b1, 32'hB1B2B3B4},
        '{1'b1, 1'b1, 1'b0, 6'h10, 32'h11223344, 4'hA, 1'b0, 32'h0},
        '{1'b0, 1'b0, 1'b1, 6'h3F, 32'h55555555, 4'h0, 1'b1, 32'hA122A344},
        '{1'b1, 1'b0, 1'b1, 6'h11, 32'h0,        4'hF, 1'b0, 32'h0},
        '{1'b1, 1'b1, 1'b1, 6'h11, 32'h0,        4'hF, 1'b0, 32'h0},
        '{1'b1, 1'b0, 1'b0, 6'h11, 32'hFFFFFFFF, 4'hF, 1'b0, 32'h0},
        '{1'b0, 1'b0, 1'b1, 6'h00, 32'h0,        4'hF, 1'b1, 32'hB1B2B3B4},
        '{1'b0, 1'b1, 1'b1, 6'h00, 32'h0,        4'hF, 1'b0, 32'h0},
        '{1'b0, 1'b1, 1'b1, 6'h00, 32'h0,        4'hF, 1'b0, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drv(input logic ld, input logic rd, input logic sel,
                       input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        adv       = ~ld;
        rd_wr_n   = rd;
        sel_a_n   = ~sel;
        sel_b     = 1'b1;
        sel_c_n   = 1'b0;
        addr      = a;
        wdata     = d;
        lane_we_n = be;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nbad++;
            ntot++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

    initial begin
        logic [31:0] bd [4];
        logic [31:0] rexp [5];
        bd = '{32'h0A0B0C0D, 32'h1A1B1C1D, 32'h2A2B2C2D, 32'h3A3B3C3D};
        rst = 1'b1; hold = 1'b0; burst_lin = 1'b0; out_en_n = 1'b0;
        drv(1'b0, 1'b1, 1'b1, 6'h0, 32'h0, 4'hF);
        @(negedge clk);
        tick(); tick();
        // R10 reset state
        chk("R10 valid after reset", {31'b0, rdata_valid}, 32'h0);
        chk("R10 drive after reset", {31'b0, rdata_drive}, 32'h0);
        chk("R10 rdata after reset", rdata, 32'h0);
        rst = 1'b0;

        // Vector table: R1 R2 R3 R6 R8 R9
        for (int i = 0; i < 14; i++) begin
            drv(VECS[i].ld, VECS[i].rd, VECS[i].sel, VECS[i].a, VECS[i].wd, VECS[i].be_n);
            tick();
            chk($sformatf("R1/R2/R3/R6/R8/R9 vec %0d valid", i), {31'b0, rdata_valid}, {31'b0, VECS[i].ev});
            chk($sformatf("R9 vec %0d drive", i), {31'b0, rdata_drive}, {31'b0, VECS[i].ev});
            chk($sformatf("R2/R3/R8 vec %0d data", i), rdata, VECS[i].ed);
        end

        // R4 R5: interleaved write burst from 0x21 -> 21,20,23,22
        burst_lin = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (k == 0)      drv(1'b1, 1'b0, 1'b1, 6'h21, 32'h0, 4'hF);
            else if (k < 4)  drv(1'b0, 1'b1, 1'b0, 6'h3C, 32'h0, 4'hF);
            else             drv(k == 4, 1'b1, 1'b0, 6'h00, 32'h0, 4'hF);
            if (k >= 2) begin
                wdata     = bd[k-2];
                lane_we_n = 4'h0;
            end
            tick();
        end
        // R4 R5: linear read burst from 0x21 -> 21,22,23,20, wraps to 21
        burst_lin = 1'b1;
        rexp = '{bd[0], bd[3], bd[2], bd[1], bd[0]};
        for (int k = 0; k < 7; k++) begin
            if (k == 0)      drv(1'b1, 1'b1, 1'b1, 6'h21, 32'h0, 4'hF);
            else if (k < 5)  drv(1'b0, 1'b0, 1'b0, 6'h15, 32'h0, 4'h0);
            else             drv(k == 5, 1'b1, 1'b0, 6'h00, 32'h0, 4'hF);
            tick();
            if (k >= 2) begin
                chk($sformatf("R5 linear beat %0d valid", k-2), {31'b0, rdata_valid}, 32'h1);
                chk($sformatf("R4/R5 linear beat %0d data", k-2), rdata, rexp[k-2]);
            end
        end
        burst_lin = 1'b0;

        // R7: hold keeps a read result on the bus; R6 via sel_b low
        drv(1'b1, 1'b1, 1'b1, 6'h20, 32'h0, 4'hF); tick();
        drv(1'b1, 1'b1, 1'b1, 6'h00, 32'h0, 4'hF); sel_b = 1'b0; tick();
        drv(1'b0, 1'b1, 1'b1, 6'h00, 32'h0, 4'hF); tick();
        chk("R2 read before hold", rdata, bd[1]);
        drv(1'b1, 1'b0, 1'b1, 6'h05, 32'h0, 4'h0); hold = 1'b1; tick();
        chk("R7 valid held", {31'b0, rdata_valid}, 32'h1);
        chk("R7 data held", rdata, bd[1]);
        hold = 1'b0;
        drv(1'b1, 1'b1, 1'b1, 6'h00, 32'h0, 4'hF); sel_c_n = 1'b1; tick();
        chk("R6 deselect via sel_b", {31'b0, rdata_valid}, 32'h0);

        // R9: output enable gates the bus only
        drv(1'b1, 1'b1, 1'b1, 6'h21, 32'h0, 4'hF); tick();
        drv(1'b1, 1'b1, 1'b0, 6'h00, 32'h0, 4'hF); tick();
        drv(1'b0, 1'b1, 1'b0, 6'h00, 32'h0, 4'hF); tick();
        out_en_n = 1'b1; #1;
        chk("R9 valid with enable off", {31'b0, rdata_valid}, 32'h1);
        chk("R9 drive with enable off", {31'b0, rdata_drive}, 32'h0);
        chk("R9 rdata with enable off", rdata, 32'h0);
        out_en_n = 1'b0; #1;
        chk("R9 rdata with enable on", rdata, bd[0]);

        // R7: a held cycle writes nothing; next enabled edge takes lane 0 only
        drv(1'b1, 1'b0, 1'b1, 6'h20, 32'h0, 4'hF); tick();
        drv(1'b1, 1'b1, 1'b0, 6'h00, 32'h0, 4'hF); tick();
        drv(1'b0, 1'b1, 1'b0, 6'h00, 32'hEEEEEEEE, 4'h0); hold = 1'b1; tick();
        hold = 1'b0;
        drv(1'b0, 1'b1, 1'b0, 6'h00, 32'hFFFFFFFF, 4'hE); tick();
        drv(1'b1, 1'b1, 1'b1, 6'h20, 32'h0, 4'hF); tick();
        drv(1'b1, 1'b1, 1'b0, 6'h00, 32'h0, 4'hF); tick();
        drv(1'b0, 1'b1, 1'b0, 6'h00, 32'h0, 4'hF); tick();
        chk("R7/R8 no write during hold, lane 0 only", rdata, 32'h1A1B1CFF);

        // R10: reset mid-read, then continue cycles stay idle
        drv(1'b1, 1'b1, 1'b1, 6'h21, 32'h0, 4'hF); tick();
        drv(1'b0, 1'b1, 1'b1, 6'h00, 32'h0, 4'hF); rst = 1'b1; tick();
        rst = 1'b0;
        chk("R10 valid after mid reset", {31'b0, rdata_valid}, 32'h0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk($sformatf("R10 continue after reset %0d", k), {31'b0, rdata_valid}, 32'h0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

endmodule